// File: doc/BRIEF.md
# Outbound Address Window Translator

This block converts outbound memory addresses from the on-chip interconnect into PCIe bus addresses. It has a small set of software-programmed windows. Every incoming address is first rebased into an internal address space by subtracting a fixed interconnect offset. The rebased address is then compared against each enabled window. A window that matches replaces the rebased address with its own target region, and the block reports which window was used. An address that no window claims is flagged as a miss.

Each window has two 64-bit registers. The match base says where the window sits in the internal space. The target register says where that region lands on the PCIe bus. Software reaches both registers as pairs of 32-bit words through a simple write strobe and a combinational read port. A lookup is presented for one cycle, and its result appears on registered outputs one cycle later.

Top module: `obx_xlate`

## Requirements
- R1: During reset and after it, every window register reads back as zero, and all lookup outputs (valid, hit, miss, window index, address) are low.
- R2: A register write lands in the addressed 32-bit word and can be read back whole, including bits 1:0. For window n, the base low and high words sit at byte offsets 0xD20+8n and 0xD24+8n, and the target low and high words at 0xD40+8n and 0xD44+8n.
- R3: The internal address is the lookup address minus AXI_OFFSET. The window base is the base high word concatenated with bits 31:2 of the base low word, with bits 1:0 forced to zero. A window matches when base <= internal address < base + WIN_MIB x 2^20. The comparison uses all 64 bits.
- R4: One clock after a lookup is presented, out_valid is high. On a hit, out_addr equals the target register plus (internal address minus base).
- R5: A window whose base low word bit 0 (enable) is clear never matches.
- R6: A lookup address below AXI_OFFSET always produces a miss, whatever the windows hold.
- R7: When several windows match, the lowest-numbered window wins and its index appears on out_win.
- R8: Each lookup result asserts exactly one of out_hit and out_miss. In cycles with no result, both stay low.
- R9: Bit 1 of the base low word (size-select) is stored and read back, but it changes neither the match range nor the output address.
- R10: Writes to offsets outside the window registers are ignored: such offsets read back as zero, and the window registers keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 64 | Interconnect address to translate |
| out_valid | output | 1 | Lookup result present |
| out_hit | output | 1 | Result matched a window |
| out_miss | output | 1 | Result matched no window |
| out_win | output | 1 | Index of the winning window |
| out_addr | output | 64 | Translated PCIe address (zero on miss) |

## Verification
Lookups are placed on the first and last byte of a window, on the byte just past its end and on the byte just before its start. This separates an off-by-one in either bound from a correct range check. A window based above 4 GiB shows whether the high word takes part in the compare. Addresses one below the offset, and exactly at it, against a window based at zero, separate correct underflow handling from a wrapped subtraction. Overlapping windows, followed by disabling the lower one, distinguish priority order from enable gating. A base low word with both flag bits set shows that those bits are masked from the base yet still kept for readback.

// File: rtl/obx_pkg.sv
// Package obx_pkg
// Shared constants and the window configuration type for the outbound
// address translator. Assumes 64-bit addresses and 32-bit register words.
package obx_pkg;

    localparam int OBX_ADDR_W    = 64;
    localparam int OBX_DATA_W    = 32;
    localparam int OBX_REG_AW    = 12;
    localparam int OBX_MIB_SHIFT = 20;
    localparam int OBX_STRIDE    = 8;

    localparam logic [OBX_REG_AW-1:0] OBX_BASE_LO_OFF = 12'hD20;
    localparam logic [OBX_REG_AW-1:0] OBX_BASE_HI_OFF = 12'hD24;
    localparam logic [OBX_REG_AW-1:0] OBX_TGT_LO_OFF  = 12'hD40;
    localparam logic [OBX_REG_AW-1:0] OBX_TGT_HI_OFF  = 12'hD44;

    typedef struct packed {
        logic [OBX_ADDR_W-1:0] base;     // match base, flag bits cleared
        logic [OBX_ADDR_W-1:0] target;   // PCIe region start
        logic                  size_sel; // stored flag, no effect on match
        logic                  enable;   // window enable
    } obx_win_t;

endpackage

// File: rtl/obx_regfile.sv
// Module obx_regfile
// Holds the base and target words of every window and decodes the
// register port. Writes land on the clock edge; reads are combinational.
// Assumes NUM_WIN <= 4 so the base and target blocks do not overlap.
module obx_regfile
    import obx_pkg::*;
#(
    parameter int NUM_WIN = 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            reg_wr,
    input  logic [OBX_REG_AW-1:0]           reg_addr,
    input  logic [OBX_DATA_W-1:0]           reg_wdata,
    output logic [OBX_DATA_W-1:0]           reg_rdata,
    output obx_win_t [NUM_WIN-1:0]          win_cfg
);

    logic [NUM_WIN-1:0][OBX_DATA_W-1:0] base_lo_q;
    logic [NUM_WIN-1:0][OBX_DATA_W-1:0] base_hi_q;
    logic [NUM_WIN-1:0][OBX_DATA_W-1:0] tgt_lo_q;
    logic [NUM_WIN-1:0][OBX_DATA_W-1:0] tgt_hi_q;

    // Byte offset of a word of window idx
    function automatic logic [OBX_REG_AW-1:0] word_off(
        input logic [OBX_REG_AW-1:0] first, input int idx);
        return first + OBX_REG_AW'(idx * OBX_STRIDE);
    endfunction

    // Register storage: clear on reset, update the one addressed word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_lo_q <= '0;
            base_hi_q <= '0;
            tgt_lo_q  <= '0;
            tgt_hi_q  <= '0;
        end else if (reg_wr) begin
            for (int i = 0; i < NUM_WIN; i++) begin
                if (reg_addr == word_off(OBX_BASE_LO_OFF, i)) base_lo_q[i] <= reg_wdata;
                if (reg_addr == word_off(OBX_BASE_HI_OFF, i)) base_hi_q[i] <= reg_wdata;
                if (reg_addr == word_off(OBX_TGT_LO_OFF, i))  tgt_lo_q[i]  <= reg_wdata;
                if (reg_addr == word_off(OBX_TGT_HI_OFF, i))  tgt_hi_q[i]  <= reg_wdata;
            end
        end
    end

    // Read mux: unmatched offsets return zero
    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NUM_WIN; i++) begin
            if (reg_addr == word_off(OBX_BASE_LO_OFF, i)) reg_rdata = base_lo_q[i];
            if (reg_addr == word_off(OBX_BASE_HI_OFF, i)) reg_rdata = base_hi_q[i];
            if (reg_addr == word_off(OBX_TGT_LO_OFF, i))  reg_rdata = tgt_lo_q[i];
            if (reg_addr == word_off(OBX_TGT_HI_OFF, i))  reg_rdata = tgt_hi_q[i];
        end
    end

    // Unpack the stored words into one configuration record per window
    for (genvar g = 0; g < NUM_WIN; g++) begin : g_cfg
        assign win_cfg[g].base     = {base_hi_q[g], base_lo_q[g][OBX_DATA_W-1:2], 2'b00};
        assign win_cfg[g].target   = {tgt_hi_q[g], tgt_lo_q[g]};
        assign win_cfg[g].size_sel = base_lo_q[g][1];
        assign win_cfg[g].enable   = base_lo_q[g][0];
    end

endmodule

// File: rtl/obx_win_match.sv
// Module obx_win_match
// Range check and address rebasing for one window. Assumes the caller
// supplies the already rebased internal address and a flag saying the
// rebase did not underflow.
module obx_win_match
    import obx_pkg::*;
#(
    parameter int WIN_MIB = 16
) (
    input  logic [OBX_ADDR_W-1:0] int_addr,
    input  logic                  addr_ok,
    input  obx_win_t              cfg,
    output logic                  hit,
    output logic [OBX_ADDR_W-1:0] xaddr
);

    localparam logic [OBX_ADDR_W-1:0] WIN_BYTES =
        OBX_ADDR_W'(WIN_MIB) << OBX_MIB_SHIFT;

    logic [OBX_ADDR_W-1:0] delta;

    // Distance into the window; valid only when int_addr >= base
    assign delta = int_addr - cfg.base;

    // Hit when enabled, rebase valid and base <= int_addr < base + size
    assign hit = addr_ok && cfg.enable && (int_addr >= cfg.base) && (delta < WIN_BYTES);

    // Target address keeps the offset into the window
    assign xaddr = cfg.target + delta;

endmodule

// File: rtl/obx_prio_sel.sv
// Module obx_prio_sel
// Picks the lowest-numbered matching window and forwards its index and
// translated address. Assumes per-window hit and address vectors.
module obx_prio_sel
    import obx_pkg::*;
#(
    parameter int NUM_WIN = 2,
    parameter int IDX_W   = 1
) (
    input  logic [NUM_WIN-1:0]                 hit_vec,
    input  logic [NUM_WIN-1:0][OBX_ADDR_W-1:0] xaddr_vec,
    output logic                               any_hit,
    output logic [IDX_W-1:0]                   sel_idx,
    output logic [OBX_ADDR_W-1:0]              sel_addr
);

    // Scan from the top so the lowest matching index is the last to write
    always_comb begin
        any_hit  = 1'b0;
        sel_idx  = '0;
        sel_addr = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                any_hit  = 1'b1;
                sel_idx  = IDX_W'(i);
                sel_addr = xaddr_vec[i];
            end
        end
    end

endmodule

// File: rtl/obx_xlate.sv
// Module obx_xlate
// Top of the outbound address translator. Rebases each lookup by
// AXI_OFFSET, matches it against all windows in parallel, and registers
// the prioritised result one cycle later. Assumes lookups are single-cycle
// strobes and that register writes take effect on the next lookup.
module obx_xlate
    import obx_pkg::*;
#(
    parameter int                    NUM_WIN    = 2,
    parameter int                    WIN_MIB    = 16,
    parameter logic [OBX_ADDR_W-1:0] AXI_OFFSET = 64'h0000_0000_4000_0000,
    localparam int                   IDX_W      = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr,
    input  logic [OBX_REG_AW-1:0] reg_addr,
    input  logic [OBX_DATA_W-1:0] reg_wdata,
    output logic [OBX_DATA_W-1:0] reg_rdata,
    input  logic                  lk_valid,
    input  logic [OBX_ADDR_W-1:0] lk_addr,
    output logic                  out_valid,
    output logic                  out_hit,
    output logic                  out_miss,
    output logic [IDX_W-1:0]      out_win,
    output logic [OBX_ADDR_W-1:0] out_addr
);

    obx_win_t [NUM_WIN-1:0]          win_cfg;
    logic [NUM_WIN-1:0]              hit_vec;
    logic [NUM_WIN-1:0][OBX_ADDR_W-1:0] xaddr_vec;
    logic [NUM_WIN-1:0]              win_enable;
    logic [OBX_ADDR_W-1:0]           int_addr;
    logic                            addr_ok;
    logic                            any_hit;
    logic [IDX_W-1:0]                sel_idx;
    logic [OBX_ADDR_W-1:0]           sel_addr;

    obx_regfile #(
        .NUM_WIN (NUM_WIN)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .win_cfg   (win_cfg)
    );

    // Rebase into the internal space; flag underflow
    assign addr_ok  = (lk_addr >= AXI_OFFSET);
    assign int_addr = lk_addr - AXI_OFFSET;

    // One matcher per window
    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        obx_win_match #(
            .WIN_MIB (WIN_MIB)
        ) u_match (
            .int_addr (int_addr),
            .addr_ok  (addr_ok),
            .cfg      (win_cfg[g]),
            .hit      (hit_vec[g]),
            .xaddr    (xaddr_vec[g])
        );
        assign win_enable[g] = win_cfg[g].enable;
    end

    obx_prio_sel #(
        .NUM_WIN (NUM_WIN),
        .IDX_W   (IDX_W)
    ) u_sel (
        .hit_vec   (hit_vec),
        .xaddr_vec (xaddr_vec),
        .any_hit   (any_hit),
        .sel_idx   (sel_idx),
        .sel_addr  (sel_addr)
    );

    // Result register: one cycle after the lookup strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_hit   <= 1'b0;
            out_miss  <= 1'b0;
            out_win   <= '0;
            out_addr  <= '0;
        end else begin
            out_valid <= lk_valid;
            out_hit   <= lk_valid && any_hit;
            out_miss  <= lk_valid && !any_hit;
            out_win   <= (lk_valid && any_hit) ? sel_idx : '0;
            out_addr  <= (lk_valid && any_hit) ? sel_addr : '0;
        end
    end

endmodule

// File: rtl/obx_xlate_chk.sv
// Module obx_xlate_chk
// Protocol and ordering checks on the translator's result port, bound to
// every obx_xlate instance. Assumes the top's window enable vector.
module obx_xlate_chk
    import obx_pkg::*;
#(
    parameter int                    NUM_WIN    = 2,
    parameter int                    IDX_W      = 1,
    parameter logic [OBX_ADDR_W-1:0] AXI_OFFSET = '0
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  lk_valid,
    input logic [OBX_ADDR_W-1:0] lk_addr,
    input logic                  out_valid,
    input logic                  out_hit,
    input logic                  out_miss,
    input logic [IDX_W-1:0]      out_win,
    input logic [NUM_WIN-1:0]    win_enable
);

    logic [NUM_WIN-1:0] enable_d;

    // Enables as seen by the lookup that produced the current result
    always_ff @(posedge clk) begin
        if (!rst_n) enable_d <= '0;
        else        enable_d <= win_enable;
    end

    // R8
    hit_miss_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($countones({out_hit, out_miss}) == 1));

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!out_hit && !out_miss));

    // R4
    result_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_valid == $past(lk_valid)));

    // R6
    below_offset_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(lk_valid) && ($past(lk_addr) < AXI_OFFSET)) |-> out_miss);

    // R5
    hit_enabled_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_hit |-> enable_d[out_win]);

endmodule

bind obx_xlate obx_xlate_chk #(
    .NUM_WIN    (NUM_WIN),
    .IDX_W      (IDX_W),
    .AXI_OFFSET (AXI_OFFSET)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_valid   (lk_valid),
    .lk_addr    (lk_addr),
    .out_valid  (out_valid),
    .out_hit    (out_hit),
    .out_miss   (out_miss),
    .out_win    (out_win),
    .win_enable (win_enable)
);

// File: tb/obx_xlate_tb.sv
`timescale 1ns/1ps
module obx_xlate_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        lk_valid = 1'b0;
    logic [63:0] lk_addr = '0;
    logic        out_valid, out_hit, out_miss;
    logic [0:0]  out_win;
    logic [63:0] out_addr;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // Offset 0x4000_0000, window size 16 MiB = 0x0100_0000
    obx_xlate #(.NUM_WIN(2), .WIN_MIB(16), .AXI_OFFSET(64'h4000_0000)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_valid(lk_valid),
        .lk_addr(lk_addr), .out_valid(out_valid), .out_hit(out_hit),
        .out_miss(out_miss), .out_win(out_win), .out_addr(out_addr));

    always #2.5 clk = ~clk;

    task automatic check64(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_check(input string tag, input logic [11:0] a, input logic [31:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1;
        check64(tag, 64'(reg_rdata), 64'(exp));
    endtask

    // Drive one lookup, sample the result at the next falling edge
    task automatic lookup(input string tag, input logic [63:0] a, input bit exp_hit,
                          input logic [0:0] exp_win, input logic [63:0] exp_addr);
        @(negedge clk);
        lk_valid = 1'b1; lk_addr = a;
        @(negedge clk);
        lk_valid = 1'b0;
        check64({tag, " valid"}, 64'(out_valid), 64'd1);
        check64({tag, " hit"},   64'(out_hit),   64'(exp_hit));
        check64({tag, " miss"},  64'(out_miss),  64'(!exp_hit));
        if (exp_hit) begin
            check64({tag, " win"},  64'(out_win), 64'(exp_win));
            check64({tag, " addr"}, out_addr,     exp_addr);
        end
    endtask

    task automatic t_reset;
        check64("R1 out_valid in reset", 64'(out_valid), 64'd0);
        check64("R1 out_addr in reset",  out_addr,       64'd0);
        rst_n = 1'b1;
        reg_check("R1 base0 lo", 12'hD20, 32'h0);
        reg_check("R1 base1 hi", 12'hD2C, 32'h0);
        reg_check("R1 tgt1 lo",  12'hD48, 32'h0);
        lookup("R5 all disabled after reset", 64'h5000_0000, 1'b0, 1'b0, 64'h0);
    endtask

    task automatic t_regrw;
        reg_write(12'hD20, 32'h1000_0001);
        reg_write(12'hD24, 32'h0000_0000);
        reg_write(12'hD40, 32'h0000_0000);
        reg_write(12'hD44, 32'h0000_0008);
        reg_write(12'hD28, 32'h0000_0001);
        reg_write(12'hD2C, 32'h0000_0001);
        reg_write(12'hD48, 32'hC000_0000);
        reg_write(12'hD4C, 32'h0000_0000);
        reg_check("R2 base0 lo", 12'hD20, 32'h1000_0001);
        reg_check("R2 tgt0 hi",  12'hD44, 32'h0000_0008);
        reg_check("R2 base1 hi", 12'hD2C, 32'h0000_0001);
        reg_check("R2 tgt1 lo",  12'hD48, 32'hC000_0000);
    endtask

    task automatic t_unmapped;
        reg_write(12'hD30, 32'hFFFF_FFFF);
        reg_write(12'hD50, 32'hFFFF_FFFF);
        reg_check("R10 gap reads zero",   12'hD30, 32'h0);
        reg_check("R10 above reads zero", 12'hD50, 32'h0);
        reg_check("R10 base0 kept",       12'hD20, 32'h1000_0001);
        reg_check("R10 tgt1 kept",        12'hD48, 32'hC000_0000);
    endtask

    task automatic t_translate;
        lookup("R4 mid window",   64'h5000_1234, 1'b1, 1'b0, 64'h8_0000_1234);
        lookup("R3 first byte",   64'h5000_0000, 1'b1, 1'b0, 64'h8_0000_0000);
        lookup("R3 last byte",    64'h50FF_FFFF, 1'b1, 1'b0, 64'h8_00FF_FFFF);
        lookup("R3 past end",     64'h5100_0000, 1'b0, 1'b0, 64'h0);
        lookup("R3 before start", 64'h4FFF_FFFF, 1'b0, 1'b0, 64'h0);
        lookup("R3 high word",    64'h1_4000_0010, 1'b1, 1'b1, 64'hC000_0010);
    endtask

    task automatic t_below_offset;
        reg_write(12'hD28, 32'h0000_0001);
        reg_write(12'hD2C, 32'h0000_0000);
        reg_write(12'hD48, 32'hA000_0000);
        lookup("R6 below offset",   64'h3FFF_FFFF, 1'b0, 1'b0, 64'h0);
        lookup("R6 at offset",      64'h4000_0000, 1'b1, 1'b1, 64'hA000_0000);
    endtask

    task automatic t_priority;
        reg_write(12'hD28, 32'h1000_0001);
        lookup("R7 overlap low wins", 64'h5000_0040, 1'b1, 1'b0, 64'h8_0000_0040);
        reg_write(12'hD20, 32'h1000_0000);
        lookup("R5 win0 disabled",    64'h5000_0040, 1'b1, 1'b1, 64'hA000_0040);
    endtask

    task automatic t_size_flag;
        reg_write(12'hD20, 32'h2000_0003);
        reg_check("R9 flags read back", 12'hD20, 32'h2000_0003);
        lookup("R9 masked base",  64'h6000_0000, 1'b1, 1'b0, 64'h8_0000_0000);
        lookup("R9 last byte",    64'h60FF_FFFF, 1'b1, 1'b0, 64'h8_00FF_FFFF);
        lookup("R9 size unchanged", 64'h6100_0000, 1'b0, 1'b0, 64'h0);
    endtask

    task automatic t_idle;
        @(negedge clk);
        @(negedge clk);
        check64("R8 idle valid", 64'(out_valid), 64'd0);
        check64("R8 idle hit",   64'(out_hit),   64'd0);
        check64("R8 idle miss",  64'(out_miss),  64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        t_regrw;
        t_unmapped;
        t_translate;
        t_below_offset;
        t_priority;
        t_size_flag;
        t_idle;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule